// File: doc/BRIEF.md
# Instruction-Injection Memory Loader

This block shares the bus of an 8-bit processor. It gives a controller that cannot drive the address bus access to any RAM location. It does this by supplying bytes on the data bus. It answers the processor's vector reads with an address of its choosing. Then it feeds a stream of no-operation opcodes, so the processor's own program counter sweeps the address range. On each instruction fetch inside that range, the block accesses RAM at the address already on the bus. It writes the byte before the processor samples the data bus, or it reads the RAM byte out.

There are two modes. A boot load holds the processor in reset and starts its clock. It then releases reset, answers the reset vector, and writes an image from a source port into RAM. It finishes with a second reset and raises a write-protect flag for the loaded region. A runtime access raises a non-maskable interrupt and answers the interrupt vector. It then reads or writes a range while feeding no-ops, and ends by injecting a return-from-interrupt opcode so the interrupted program resumes. Read bytes leave on a valid/ready port. A lockout flag tells other bus masters that the loader owns the bus.

Top module: `inject_loader`

## Requirements
- R1: After reset the block is idle. lockout=0, cpu_res_n=1, cpu_nmi_n=1, cpu_rdy=1, clk_run=1, inj_en=0, ram_we=0, ram_oe=0, rom_wp=0 and rd_valid=0.
- R2: The boot phase is accepted on boot_go while idle. The block first holds cpu_res_n=0 with clk_run=0 for RST_CYC clocks. It then holds cpu_res_n=0 with clk_run=1 for another RST_CYC clocks, and then releases reset. cpu_nmi_n stays 1 throughout.
- R3: After boot reset release, a read bus cycle at 0xFFFC is answered on inj_data with the low byte of base. A read at 0xFFFD is answered with the high byte. Other cycles before that are not injected (inj_en=0).
- R4: During boot load, every bus cycle is injected with 0xEA (NOP). A fetch (cpu_sync=1, cpu_rw=1) at address base+k, where k is the next offset, asserts ram_we with ram_wdata equal to src_byte, and src_idx=k. Cycles without cpu_sync never write.
- R5: The fetch that writes offset len-1 is followed by cpu_res_n=0 with clk_run=1 for RST_CYC clocks. After that, reset is released, lockout falls and rom_wp=1.
- R6: The runtime phase is accepted on rt_go while idle and drives cpu_nmi_n=0. Bus cycles before the vector, such as stack pushes, pass through (inj_en=0). Reads at 0xFFFA and 0xFFFB are answered with the low and high bytes of base. cpu_nmi_n returns to 1 after the 0xFFFB read.
- R7: In a runtime write (rt_write=1), a fetch at base+k asserts ram_we with ram_wdata=src_byte and src_idx=k, and the fetch is injected with 0xEA.
- R8: In a runtime read (rt_write=0), a fetch at base+k asserts ram_oe. The ram_rdata byte appears on rd_data with rd_valid=1 on the next cycle, in ascending address order. If the output slot is full (rd_valid=1, rd_ready=0) at such a fetch, the block drives cpu_rdy=0, performs no access, and serves the same address on the repeated fetch.
- R9: After len accesses, the fetch at base+len is injected with 0x40 (RTI). Later cycles pass through (inj_en=0) up to and including the next fetch, after which lockout falls.
- R10: lockout is 1 from the cycle after an accepted go until the end of the phase. Every ram_we or ram_oe from the block happens with lockout=1.
- R11: boot_go and rt_go are ignored while a phase is in progress.
- R12: A fetch at an address other than base+k during the load or access phase causes no ram_we or ram_oe, and it is still injected with 0xEA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_go | input | 1 | Start a boot image load |
| rt_go | input | 1 | Start a runtime access |
| rt_write | input | 1 | Runtime direction: 1 write, 0 read |
| base | input | ADDR_W | First address of the range |
| len | input | LEN_W | Number of bytes, at least 1 |
| src_idx | output | LEN_W | Offset of the byte requested from the source |
| src_byte | input | 8 | Source byte at src_idx |
| bus_cyc | input | 1 | A processor bus cycle is present this clock |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rw | input | 1 | 1 read, 0 write |
| cpu_sync | input | 1 | Opcode fetch marker |
| inj_en | output | 1 | Block drives the processor data bus |
| inj_data | output | 8 | Injected byte |
| ram_we | output | 1 | RAM write strobe |
| ram_oe | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cpu_res_n | output | 1 | Processor reset, active low |
| cpu_nmi_n | output | 1 | Processor NMI, active low |
| cpu_rdy | output | 1 | Processor ready, low stalls |
| clk_run | output | 1 | Processor clock enable |
| lockout | output | 1 | Loader owns the bus |
| rom_wp | output | 1 | Loaded region is write-protected |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer takes the read byte |

## Verification
The hardest condition to reach is the full output slot at the moment of a read fetch. That needs a byte left unconsumed across a dummy cycle while the emulated processor fetches the next address. The bench holds rd_ready low for one runtime read, then repeats the stalled fetch twice: once with the slot still full, and once after a one-cycle ready pulse. Mismatched fetch addresses and go pulses are also injected in the middle of a phase. This shows that the pointer and the phase ignore them.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BHOLD, S_BCLK, S_BVEC, S_BLOAD, S_BREST, S_RNMI, S_RACC, S_RRTI
  } ldr_state_t;

  localparam logic [7:0]  OP_NOP  = 8'hEA;
  localparam logic [7:0]  OP_RTI  = 8'h40;
  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RES = 16'hFFFC;

  // byte of the start address answered at a vector read: even -> low, odd -> high
  function automatic logic [7:0] vec_reply(input logic [15:0] start, input logic odd);
    return odd ? start[15:8] : start[7:0];
  endfunction
endpackage

// File: rtl/ldr_ptr.sv
module ldr_ptr #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic [LEN_W-1:0]  cnt,
  output logic              last,
  output logic              done
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cnt    <= '0;
    end else if (load) begin
      base_q <= base_in;
      len_q  <= len_in;
      cnt    <= '0;
    end else if (adv && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ptr  = base_q + ADDR_W'(cnt);
  assign done = (cnt == len_q);
  assign last = (cnt == len_q - 1'b1);

  // R9
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done || $past(load)));
endmodule

// File: rtl/ldr_rdbuf.sv
module ldr_rdbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  output logic       full,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (push) begin
      rd_valid <= 1'b1;
      rd_data  <= din;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign full = rd_valid && !rd_ready;

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/inject_loader.sv
module inject_loader
  import ldr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_go,
  input  logic              rt_go,
  input  logic              rt_write,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  src_idx,
  input  logic [7:0]        src_byte,
  input  logic              bus_cyc,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_sync,
  output logic              inj_en,
  output logic [7:0]        inj_data,
  output logic              ram_we,
  output logic              ram_oe,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              cpu_res_n,
  output logic              cpu_nmi_n,
  output logic              cpu_rdy,
  output logic              clk_run,
  output logic              lockout,
  output logic              rom_wp,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              rd_ready
);
  localparam int TW = $clog2(RST_CYC + 1);

  ldr_state_t        state;
  logic [TW-1:0]     tmr;
  logic              wr_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] ptr;
  logic              last, done, full;

  // named events for the assertions and the next-state logic
  logic fetch, rd_cyc, vec_hit, vec_odd, hit, stall, access, rti_hit, tmr_end, go_ok;

  assign fetch   = bus_cyc && cpu_sync && cpu_rw;
  assign rd_cyc  = bus_cyc && cpu_rw;
  assign vec_odd = cpu_addr[0];
  assign vec_hit = rd_cyc && (
      (state == S_BVEC && (cpu_addr | ADDR_W'(1)) == (VEC_RES | 16'h1)) ||
      (state == S_RNMI && (cpu_addr | ADDR_W'(1)) == (VEC_NMI | 16'h1)));
  assign hit     = fetch && (cpu_addr == ptr) && !done &&
                   (state == S_BLOAD || state == S_RACC);
  assign stall   = hit && state == S_RACC && !wr_q && full;
  assign access  = hit && !stall;
  assign rti_hit = fetch && state == S_RACC && done && (cpu_addr == ptr);
  assign tmr_end = (tmr == TW'(RST_CYC - 1));
  assign go_ok   = state == S_IDLE;

  ldr_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(go_ok && (boot_go || rt_go)), .base_in(base), .len_in(len),
    .adv(access), .ptr(ptr), .cnt(src_idx), .last(last), .done(done)
  );

  ldr_rdbuf u_rdbuf (
    .clk(clk), .rst_n(rst_n),
    .push(access && state == S_RACC && !wr_q), .din(ram_rdata),
    .full(full), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tmr     <= '0;
      wr_q    <= 1'b0;
      start_q <= '0;
      rom_wp  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          tmr <= '0;
          start_q <= base;
          if (boot_go) begin
            state  <= S_BHOLD;
            rom_wp <= 1'b0;
          end else if (rt_go) begin
            state <= S_RNMI;
            wr_q  <= rt_write;
          end
        end
        S_BHOLD, S_BCLK, S_BREST: begin
          tmr <= tmr_end ? '0 : tmr + 1'b1;
          if (tmr_end) begin
            if (state == S_BHOLD) state <= S_BCLK;
            else if (state == S_BCLK) state <= S_BVEC;
            else begin
              state  <= S_IDLE;
              rom_wp <= 1'b1;
            end
          end
        end
        S_BVEC:  if (vec_hit && vec_odd) state <= S_BLOAD;
        S_RNMI:  if (vec_hit && vec_odd) state <= S_RACC;
        S_BLOAD: if (access && last) state <= S_BREST;
        S_RACC:  if (rti_hit) state <= S_RRTI;
        S_RRTI:  if (fetch) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    inj_en   = 1'b0;
    inj_data = OP_NOP;
    if (vec_hit) begin
      inj_en   = 1'b1;
      inj_data = vec_reply(start_q, vec_odd);
    end else if (state == S_BLOAD || state == S_RACC) begin
      inj_en   = 1'b1;
      inj_data = rti_hit ? OP_RTI : OP_NOP;
    end
  end

  assign ram_we    = access && (state == S_BLOAD || wr_q);
  assign ram_oe    = access && state == S_RACC && !wr_q;
  assign ram_wdata = src_byte;
  assign cpu_res_n = !(state == S_BHOLD || state == S_BCLK || state == S_BREST);
  assign cpu_nmi_n = (state != S_RNMI);
  assign clk_run   = (state != S_BHOLD);
  assign cpu_rdy   = !stall;
  assign lockout   = (state != S_IDLE);

  // R4
  nop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (inj_en && inj_data == OP_NOP));
  // R10
  access_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_oe) |-> lockout);
  // R2
  clk_stop_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> !cpu_res_n);
  // R6
  nmi_not_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_nmi_n |-> cpu_res_n);
  // R8
  stall_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdy |-> (!ram_oe && !ram_we));
  // R11
  go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && $past(lockout) && (boot_go || rt_go)) |=> $stable(start_q));
endmodule

// File: tb/inject_loader_bench.sv
module inject_loader_bench;
  localparam int RC = 4;

  logic clk = 0, rst_n = 0;
  logic boot_go = 0, rt_go = 0, rt_write = 0, bus_cyc = 0, cpu_rw = 1, cpu_sync = 0, rd_ready = 1;
  logic [15:0] base = 0, len = 0, cpu_addr = 0, src_idx;
  logic [7:0] src_byte, ram_rdata, inj_data, ram_wdata, rd_data;
  logic inj_en, ram_we, ram_oe, cpu_res_n, cpu_nmi_n, cpu_rdy, clk_run, lockout, rom_wp, rd_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] img(input int k);  return 8'((k * 13) ^ 8'hC3); endfunction
  function automatic logic [7:0] mem(input logic [15:0] a); return 8'(a[7:0] + a[15:8] * 3); endfunction
  assign src_byte  = img(int'(src_idx));
  assign ram_rdata = mem(cpu_addr);

  inject_loader #(.RST_CYC(RC)) u_inject_loader (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic bus(input logic [15:0] a, input logic rd, input logic sy);
    @(negedge clk); bus_cyc = 1; cpu_addr = a; cpu_rw = rd; cpu_sync = sy; #1;
  endtask
  task automatic idle(); @(negedge clk); bus_cyc = 0; cpu_sync = 0; #1; endtask
  task automatic go(input bit boot, input logic [15:0] b, input logic [15:0] n, input bit w);
    @(negedge clk); bus_cyc = 0; base = b; len = n; rt_write = w;
    if (boot) boot_go = 1; else rt_go = 1;
    @(negedge clk); boot_go = 0; rt_go = 0; #1;
  endtask

  task automatic boot_run(input logic [15:0] b, input int n);
    int c;
    go(1, b, 16'(n), 0);
    c = 0; while (!clk_run && !cpu_res_n && c < 50) begin chk(cpu_nmi_n, "R2 nmi", 0, 1); c++; idle(); end
    chk(c == RC, "R2 hold", c, RC);
    c = 0; while (clk_run && !cpu_res_n && c < 50) begin c++; idle(); end
    chk(c == RC, "R2 clk", c, RC);
    bus(16'h01FF, 1, 0); chk(!inj_en && lockout, "R3 pass", inj_en, 0);
    bus(16'hFFFC, 1, 0); chk(inj_en && inj_data == b[7:0], "R3 lo", inj_data, b[7:0]);
    bus(16'hFFFD, 1, 0); chk(inj_en && inj_data == b[15:8], "R3 hi", inj_data, b[15:8]);
    bus(b + 16'd9, 1, 1); chk(!ram_we && inj_data == 8'hEA, "R12 boot", ram_we, 0);
    for (int k = 0; k < n; k++) begin
      bus(b + 16'(k), 1, 1);
      chk(ram_we && ram_wdata == img(k) && src_idx == 16'(k), "R4 wr", ram_wdata, img(k));
      chk(inj_en && inj_data == 8'hEA, "R4 nop", inj_data, 8'hEA);
      if (k != n - 1) begin
        bus(b + 16'(k + 1), 1, 0); chk(!ram_we && inj_data == 8'hEA, "R4 dummy", ram_we, 0);
      end
    end
    idle();
    c = 0; while (clk_run && !cpu_res_n && c < 50) begin chk(lockout, "R10 boot", 0, 1); c++; idle(); end
    chk(c == RC, "R5 reset2", c, RC);
    chk(!lockout && rom_wp, "R5 done", {lockout, rom_wp}, 1);
  endtask

  task automatic rt_run(input logic [15:0] b, input int n, input bit w, input bit bp);
    go(0, b, 16'(n), w);
    chk(!cpu_nmi_n && lockout, "R6 nmi", cpu_nmi_n, 0);
    @(negedge clk); boot_go = 1; bus_cyc = 1; cpu_addr = 16'h01F0; cpu_rw = 0; cpu_sync = 0; #1;
    chk(!inj_en, "R6 push", inj_en, 0);
    @(negedge clk); boot_go = 0; bus_cyc = 0; #1;
    chk(cpu_res_n && !cpu_nmi_n, "R11 ignored", cpu_res_n, 1);
    bus(16'hFFFA, 1, 0); chk(inj_en && inj_data == b[7:0], "R6 lo", inj_data, b[7:0]);
    bus(16'hFFFB, 1, 0); chk(inj_en && inj_data == b[15:8], "R6 hi", inj_data, b[15:8]);
    idle(); chk(cpu_nmi_n, "R6 release", cpu_nmi_n, 1);
    bus(b - 16'd1, 1, 1); chk(!ram_we && !ram_oe && inj_data == 8'hEA, "R12 rt", ram_oe, 0);
    for (int k = 0; k < n; k++) begin
      if (bp && k == 1) begin
        rd_ready = 0;
        bus(b + 16'(k), 1, 1); chk(!cpu_rdy && !ram_oe, "R8 stall", cpu_rdy, 0);
        chk(rd_valid && rd_data == mem(b), "R8 held", rd_data, mem(b));
        @(negedge clk); rd_ready = 1; bus_cyc = 0; #1;
      end
      bus(b + 16'(k), 1, 1);
      chk(cpu_rdy && inj_data == 8'hEA, "R7 nop", inj_data, 8'hEA);
      if (w) chk(ram_we && !ram_oe && ram_wdata == img(k) && src_idx == 16'(k), "R7 wr", ram_wdata, img(k));
      else   chk(ram_oe && !ram_we, "R8 oe", ram_oe, 1);
      if (bp && k == 0) rd_ready = 0;
      bus(b + 16'(k + 1), 1, 0);
      if (!w) chk(rd_valid && rd_data == mem(b + 16'(k)), "R8 data", rd_data, mem(b + 16'(k)));
    end
    bus(b + 16'(n), 1, 1); chk(inj_en && inj_data == 8'h40, "R9 rti", inj_data, 8'h40);
    bus(b + 16'(n + 1), 1, 0); chk(!inj_en, "R9 pass", inj_en, 0);
    bus(16'h01F1, 1, 0); chk(!inj_en && lockout, "R10 pull", lockout, 1);
    bus(16'h1234, 1, 1); chk(!inj_en && lockout, "R9 resume", inj_en, 0);
    idle(); chk(!lockout && !rd_valid, "R9 end", lockout, 0);
  endtask

  initial begin
    #200000;
    errors++; $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
  end

  initial begin
    repeat (2) @(negedge clk); rst_n = 1; #1;
    chk(!lockout && cpu_res_n && cpu_nmi_n && cpu_rdy && clk_run && !inj_en && !ram_we && !ram_oe
        && !rom_wp && !rd_valid, "R1 reset", lockout, 0);
    for (int n = 1; n <= 4; n++) boot_run(16'hF000 + 16'(n * 16'h111), n);
    boot_run(16'hC0FE, 3);
    for (int n = 1; n <= 3; n++) rt_run(16'h0200 + 16'(n * 8), n, 1, 0);
    for (int n = 1; n <= 4; n++) rt_run(16'h3FFD + 16'(n), n, 0, 0);
    rt_run(16'h0480, 3, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule